// File: doc/BRIEF.md
# Four-Rail Power Sequencer with Supervision

This controller brings up the four supply rails of a high-speed data converter one at a time in a fixed order (rail 0 first, rail 3 last). Before each rail is switched on, the controller waits a delay that software programs separately for each rail. After switching a rail on, it waits for that rail's power-good flag. Once all four rails report good, the sequence-done output rises and the controller keeps watching the rails. It watches every enabled rail for overvoltage, and every rail that has already reported good for undervoltage.

A fault is an overvoltage, an undervoltage, or a rail that does not report good in time. On any fault the controller records the cause and the rail, raises an interrupt, and switches the rails off in reverse order using the same per-rail delays. It then holds every rail off until software clears the record. Dropping the global enable runs the same reverse shutdown without recording a fault.

The comparator flags are treated as asynchronous. Each one passes through a two-flop synchronizer and a glitch filter whose length software programs.

Top module: `rail_seq_top`

## Requirements
- R1: After a synchronous active-low reset, every rail enable is 0, seq_done is 0, irq is 0 and the status word (address 5) reads 0.
- R2: Rails turn on strictly in index order 0,1,2,3, one at a time. The set of enabled rails is always a contiguous group starting at rail 0.
- R3: Addresses 0 to 3 hold the delay for rails 0 to 3 and read back what was written. Rail n turns on after the delay for rail n has run for delay+1 cycles. That countdown starts at the global enable for rail 0, and at the filtered power-good of rail n-1 for the other rails.
- R4: A rail that does not show filtered power-good within 64 cycles of being turned on causes a fault with cause code 3.
- R5: Overvoltage on an enabled rail causes a fault with cause code 2. Undervoltage on a rail that has already reported good causes cause code 1. When several rails flag at once, the lowest index is taken. On that rail, overvoltage takes precedence over undervoltage.
- R6: seq_done is 1 exactly while all four rails are up and being supervised. It is 0 while ramping.
- R7: After a fault the rails turn off from the highest enabled rail down to rail 0, each after its own delay+1 cycles. They then stay off while the fault is recorded, even with enable held high.
- R8: The status word has bit 15 = valid, bits [5:4] = cause and bits [1:0] = rail. It holds, with irq = valid, until a write to address 5 is made after the shutdown has finished. A write to address 5 at any other time has no effect.
- R9: Deasserting enable shuts the rails down in reverse order with the same delays. It returns to idle with all rails off, seq_done 0, and no fault recorded.
- R10: Address 4 holds the glitch-filter length L. A synchronized flag change is acted on only after it has persisted for L+1 cycles, so shorter pulses are ignored.
- R11: Undervoltage on a rail that has not yet reported good, and overvoltage on a rail that is not enabled, are both ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Global enable: high runs the power-up sequence, low runs the shutdown |
| pg_in | input | 4 | Per-rail power-good flags (asynchronous) |
| uv_in | input | 4 | Per-rail undervoltage flags (asynchronous) |
| ov_in | input | 4 | Per-rail overvoltage flags (asynchronous) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0-3 delays, 4 filter length, 5 status/clear |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| rail_en | output | 4 | Per-rail enable outputs |
| seq_done | output | 1 | All rails up and supervised |
| irq | output | 1 | Fault recorded |

## Verification
The bench attacks the following cases:
- **Short undervoltage pulse.** A pulse shorter than the filter window arrives on a running rail. A filter that counts one cycle too few would trip a false fault here.
- **Stalled ramp.** A rail stalls during ramp-up while undervoltage is flagged on that same rail and overvoltage on a rail that is not yet enabled. A design that supervises too early would report the wrong cause or the wrong rail instead of the timeout.
- **Simultaneous flags.** Overvoltage and undervoltage rise together on rail 0. A design with the wrong precedence reports cause 1 instead of cause 2.
- **Early clear.** A clear written during the shutdown must be ignored. A design that accepts it would restart the rails while the converter is still only partly powered.

// File: rtl/rail_seq_pkg.sv
// Package: shared types for the four-rail power sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rail_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_WAIT  = 3'd1,
        SQ_RAMP  = 3'd2,
        SQ_RUN   = 3'd3,
        SQ_SHUT  = 3'd4,
        SQ_FAULT = 3'd5
    } seq_state_t;

    typedef enum logic [1:0] {
        CZ_NONE = 2'd0,
        CZ_UV   = 2'd1,
        CZ_OV   = 2'd2,
        CZ_TMO  = 2'd3
    } fault_cause_t;

endpackage

// File: rtl/flag_filter.sv
// Module: flag_filter
// Double-flop synchronizer followed by a persistence filter. The clean
// output takes the synchronized value only after that value has differed
// from it for len+1 consecutive cycles.
// Assumes: raw may change at any time; len may change on the fly.
module flag_filter #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw,
    input  logic [FW-1:0] len,
    output logic          clean
);
    logic          s1, s2;
    logic [FW-1:0] run_cnt;

    // Synchronize the raw flag, then accept a change once it has persisted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1      <= 1'b0;
            s2      <= 1'b0;
            clean   <= 1'b0;
            run_cnt <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (s2 == clean) begin
                run_cnt <= '0;
            end else if (run_cnt >= len) begin
                clean   <= s2;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + FW'(1);
            end
        end
    end
endmodule

// File: rtl/seq_regs.sv
// Module: seq_regs
// Register file: per-rail delays, the glitch-filter length, a read mux
// that includes the fault status word, and the clear strobe.
// Assumes: address N_RAILS selects the filter length and N_RAILS+1 selects
// status/clear; a write to status/clear is a one-cycle clear request.
module seq_regs #(
    parameter int N_RAILS = 4,
    parameter int DLY_W   = 16,
    parameter int FW      = 4,
    parameter int AW      = 3,
    parameter int IW      = 2,
    parameter int DLY_RST = 4,
    parameter int FLT_RST = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [AW-1:0]                  addr,
    input  logic [DLY_W-1:0]               wdata,
    input  logic                           f_valid,
    input  logic [1:0]                     f_cause,
    input  logic [IW-1:0]                  f_rail,
    output logic [DLY_W-1:0]               rdata,
    output logic [N_RAILS-1:0][DLY_W-1:0]  dly,
    output logic [FW-1:0]                  flt_len,
    output logic                           clr
);
    localparam logic [AW-1:0] A_FLT  = AW'(N_RAILS);
    localparam logic [AW-1:0] A_STAT = AW'(N_RAILS + 1);

    // Store writes to the delay and filter-length registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_RAILS; i++) dly[i] <= DLY_W'(DLY_RST);
            flt_len <= FW'(FLT_RST);
        end else if (we) begin
            for (int i = 0; i < N_RAILS; i++)
                if (addr == AW'(i)) dly[i] <= wdata;
            if (addr == A_FLT) flt_len <= wdata[FW-1:0];
        end
    end

    // Clear request: any write to the status address.
    assign clr = we && (addr == A_STAT);

    // Select the read data for the current address.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_RAILS; i++)
            if (addr == AW'(i)) rdata = dly[i];
        if (addr == A_FLT) rdata = DLY_W'(flt_len);
        if (addr == A_STAT) begin
            rdata[DLY_W-1]  = f_valid;
            rdata[5:4]      = f_cause;
            rdata[IW-1:0]   = f_rail;
        end
    end
endmodule

// File: rtl/seq_fsm.sv
// Module: seq_fsm
// Sequencing state machine: per-rail wait then ramp, supervision while
// running, reverse-order shutdown, and the latched fault record.
// Assumes: flags are already synchronized and filtered; the rail enables
// are decoded from the state and index registers.
module seq_fsm
    import rail_seq_pkg::*;
#(
    parameter int N_RAILS = 4,
    parameter int DLY_W   = 16,
    parameter int IW      = 2,
    parameter int TMO_CYC = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  logic [N_RAILS-1:0]            pg,
    input  logic [N_RAILS-1:0]            uv,
    input  logic [N_RAILS-1:0]            ov,
    input  logic [N_RAILS-1:0][DLY_W-1:0] dly,
    input  logic                          clr,
    output logic [N_RAILS-1:0]            rail_en,
    output logic                          done,
    output logic                          f_valid,
    output logic [1:0]                    f_cause,
    output logic [IW-1:0]                 f_rail
);
    localparam int TMO_W = $clog2(TMO_CYC + 1);
    localparam int CNT_W = (DLY_W > TMO_W) ? DLY_W : TMO_W;
    localparam logic [IW-1:0] LAST = IW'(N_RAILS - 1);

    seq_state_t         st, st_n;
    logic [IW-1:0]      idx, idx_n;
    logic [CNT_W-1:0]   cnt, cnt_n;
    logic [N_RAILS-1:0] up_mask, hit;
    logic               any_hit, set_f, clr_f, cur_ov;
    logic [IW-1:0]      hit_rail;
    fault_cause_t       new_cause;
    seq_state_t         dn_st;
    logic [IW-1:0]      dn_idx;
    logic [CNT_W-1:0]   cur_dly;

    // Decode which rails are on and which have completed their ramp.
    always_comb begin
        for (int i = 0; i < N_RAILS; i++) begin
            unique case (st)
                SQ_RAMP, SQ_SHUT: rail_en[i] = (IW'(i) <= idx);
                SQ_WAIT:          rail_en[i] = (IW'(i) < idx);
                SQ_RUN:           rail_en[i] = 1'b1;
                default:          rail_en[i] = 1'b0;
            endcase
            up_mask[i] = (st == SQ_RAMP) ? (IW'(i) < idx) : rail_en[i];
        end
    end

    // Supervision hits and the lowest-index flagged rail.
    always_comb begin
        hit      = (ov & rail_en) | (uv & up_mask);
        any_hit  = (st != SQ_SHUT) && (hit != '0);
        hit_rail = '0;
        for (int i = N_RAILS - 1; i >= 0; i--)
            if (hit[i]) hit_rail = IW'(i);
        cur_ov   = ov[hit_rail] && rail_en[hit_rail];
        cur_dly  = CNT_W'(dly[idx]);
    end

    // Where a shutdown starts from the current state.
    always_comb begin
        dn_st  = SQ_SHUT;
        dn_idx = idx;
        if (st == SQ_RUN) begin
            dn_idx = LAST;
        end else if (st == SQ_WAIT) begin
            if (idx == '0) dn_st = SQ_IDLE;
            else           dn_idx = idx - IW'(1);
        end
    end

    // Next-state, index, counter and fault-record decisions.
    always_comb begin
        st_n      = st;
        idx_n     = idx;
        cnt_n     = cnt + CNT_W'(1);
        set_f     = 1'b0;
        clr_f     = 1'b0;
        new_cause = cur_ov ? CZ_OV : CZ_UV;
        unique case (st)
            SQ_IDLE: begin
                cnt_n = '0;
                if (en && !f_valid) begin
                    st_n  = SQ_WAIT;
                    idx_n = '0;
                end
            end
            SQ_WAIT: begin
                if (any_hit || !en) begin
                    set_f = any_hit;
                    st_n  = dn_st;
                    idx_n = dn_idx;
                    cnt_n = '0;
                end else if (cnt == cur_dly) begin
                    st_n  = SQ_RAMP;
                    cnt_n = '0;
                end
            end
            SQ_RAMP: begin
                if (!any_hit && !pg[idx] && cnt == CNT_W'(TMO_CYC - 1)) begin
                    set_f     = 1'b1;
                    new_cause = CZ_TMO;
                    st_n      = dn_st;
                    cnt_n     = '0;
                end else if (any_hit || !en) begin
                    set_f = any_hit;
                    st_n  = dn_st;
                    cnt_n = '0;
                end else if (pg[idx]) begin
                    cnt_n = '0;
                    if (idx == LAST) begin
                        st_n = SQ_RUN;
                    end else begin
                        st_n  = SQ_WAIT;
                        idx_n = idx + IW'(1);
                    end
                end
            end
            SQ_RUN: begin
                cnt_n = '0;
                if (any_hit || !en) begin
                    set_f = any_hit;
                    st_n  = dn_st;
                    idx_n = dn_idx;
                end
            end
            SQ_SHUT: begin
                if (cnt == cur_dly) begin
                    cnt_n = '0;
                    if (idx == '0) st_n = f_valid ? SQ_FAULT : SQ_IDLE;
                    else           idx_n = idx - IW'(1);
                end
            end
            SQ_FAULT: begin
                cnt_n = '0;
                if (clr) begin
                    clr_f = 1'b1;
                    st_n  = SQ_IDLE;
                end
            end
            default: st_n = SQ_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SQ_IDLE;
            idx <= '0;
            cnt <= '0;
        end else begin
            st  <= st_n;
            idx <= idx_n;
            cnt <= cnt_n;
        end
    end

    // Fault record: set on detection, cleared only from the fault state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_f) begin
            f_valid <= 1'b0;
            f_cause <= CZ_NONE;
            f_rail  <= '0;
        end else if (set_f) begin
            f_valid <= 1'b1;
            f_cause <= (new_cause == CZ_TMO) ? CZ_TMO : new_cause;
            f_rail  <= (new_cause == CZ_TMO) ? idx : hit_rail;
        end
    end

    assign done = (st == SQ_RUN);
endmodule

// File: rtl/rail_seq_top.sv
// Module: rail_seq_top
// Four-rail power sequencer top: flag filters, register file, sequencer.
// Assumes: comparator flags are asynchronous levels; the register port is
// a single-cycle write strobe with combinational read.
module rail_seq_top #(
    parameter int N_RAILS = 4,
    parameter int DLY_W   = 16,
    parameter int FW      = 4,
    parameter int AW      = 3,
    parameter int TMO_CYC = 64,
    parameter int DLY_RST = 4,
    parameter int FLT_RST = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [N_RAILS-1:0] pg_in,
    input  logic [N_RAILS-1:0] uv_in,
    input  logic [N_RAILS-1:0] ov_in,
    input  logic               reg_we,
    input  logic [AW-1:0]      reg_addr,
    input  logic [DLY_W-1:0]   reg_wdata,
    output logic [DLY_W-1:0]   reg_rdata,
    output logic [N_RAILS-1:0] rail_en,
    output logic               seq_done,
    output logic               irq
);
    localparam int IW    = (N_RAILS > 1) ? $clog2(N_RAILS) : 1;
    localparam int NFLAG = 3 * N_RAILS;

    logic [NFLAG-1:0]              raw_flags, clean_flags;
    logic [N_RAILS-1:0][DLY_W-1:0] dly;
    logic [FW-1:0]                 flt_len;
    logic                          clr, f_valid;
    logic [1:0]                    f_cause;
    logic [IW-1:0]                 f_rail;

    assign raw_flags = {ov_in, uv_in, pg_in};

    // One synchronizer and filter per comparator flag.
    for (genvar g = 0; g < NFLAG; g++) begin : g_flt
        flag_filter #(.FW(FW)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_flags[g]),
            .len   (flt_len),
            .clean (clean_flags[g])
        );
    end

    seq_regs #(
        .N_RAILS(N_RAILS), .DLY_W(DLY_W), .FW(FW), .AW(AW), .IW(IW),
        .DLY_RST(DLY_RST), .FLT_RST(FLT_RST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .f_valid (f_valid),
        .f_cause (f_cause),
        .f_rail  (f_rail),
        .rdata   (reg_rdata),
        .dly     (dly),
        .flt_len (flt_len),
        .clr     (clr)
    );

    seq_fsm #(
        .N_RAILS(N_RAILS), .DLY_W(DLY_W), .IW(IW), .TMO_CYC(TMO_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .pg      (clean_flags[N_RAILS-1:0]),
        .uv      (clean_flags[2*N_RAILS-1:N_RAILS]),
        .ov      (clean_flags[3*N_RAILS-1:2*N_RAILS]),
        .dly     (dly),
        .clr     (clr),
        .rail_en (rail_en),
        .done    (seq_done),
        .f_valid (f_valid),
        .f_cause (f_cause),
        .f_rail  (f_rail)
    );

    assign irq = f_valid;
endmodule

// File: rtl/seq_chk.sv
// Module: seq_chk
// Temporal checks on the sequencer ports, bound into rail_seq_top.
// Assumes: the status/clear register sits at address N_RAILS+1.
module seq_chk #(
    parameter int N_RAILS = 4,
    parameter int AW      = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic               reg_we,
    input logic [AW-1:0]      reg_addr,
    input logic [N_RAILS-1:0] rail_en,
    input logic               seq_done,
    input logic               irq
);
    localparam logic [AW-1:0] A_STAT = AW'(N_RAILS + 1);

    // R1: reset leaves all rails off and no fault.
    a_r1_reset_off: assert property (@(posedge clk)
        !rst_n |=> (rail_en == '0 && !irq && !seq_done));

    // R2: enabled rails always form a contiguous group from rail 0.
    a_r2_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en & (rail_en + 1'b1)) == '0);

    // R2: at most one rail changes per cycle.
    a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rail_en ^ $past(rail_en)) <= 1);

    // R6: done implies every rail is on.
    a_r6_done_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (rail_en == '1));

    // R7: once rails are off after a fault, they stay off.
    a_r7_fault_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && rail_en == '0) |=> (rail_en == '0));

    // R8: the interrupt holds unless a clear is written.
    a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_we && reg_addr == A_STAT)) |=> irq);

    // R9: no rail turns on while enable is low.
    a_r9_no_rise_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((rail_en & ~$past(rail_en)) == '0));
endmodule

bind rail_seq_top seq_chk #(.N_RAILS(N_RAILS), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .rail_en  (rail_en),
    .seq_done (seq_done),
    .irq      (irq)
);

// File: tb/tb_rail_seq_top.sv
// Bench for rail_seq_top: behavioural reference model compared every
// clock, plus directed checks of the requirement corner cases.
module tb_rail_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [3:0]  pg_in = '0, uv_in = '0, ov_in = '0, pg_ok = 4'hF;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd5;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  rail_en;
    logic        seq_done, irq;

    int total = 0;
    int bad = 0;
    bit model_on = 0;

    rail_seq_top dut (
        .clk(clk), .rst_n(rst_n), .en(en), .pg_in(pg_in), .uv_in(uv_in),
        .ov_in(ov_in), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rail_en(rail_en),
        .seq_done(seq_done), .irq(irq)
    );

    always #2 clk = ~clk;

    // Rail plant: a rail reports good one cycle after it is enabled.
    always @(negedge clk) pg_in <= rail_en & pg_ok;

    // ---------------- reference model ----------------
    int ms, mi, mc, mfv, mcz, mrl, mflt;
    int mdly[4];
    int s1[12], s2[12], cl[12], fc[12];

    function automatic int on_set(int s, int i);
        if (s == 2 || s == 4) return (1 << (i + 1)) - 1;
        if (s == 1) return (1 << i) - 1;
        if (s == 3) return 15;
        return 0;
    endfunction

    function automatic int good_set(int s, int i);
        if (s == 1 || s == 2) return (1 << i) - 1;
        if (s == 3) return 15;
        return 0;
    endfunction

    function automatic int mstat();
        return mfv ? (32768 + mcz * 16 + mrl) : 0;
    endfunction

    task automatic m_down();
        mc = 0;
        if (ms == 3) begin ms = 4; mi = 3; end
        else if (ms == 1) begin
            if (mi == 0) ms = 0; else begin ms = 4; mi = mi - 1; end
        end else ms = 4;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mi = 0; mc = 0; mfv = 0; mcz = 0; mrl = 0; mflt = 2;
            for (int k = 0; k < 4; k++) mdly[k] = 4;
            for (int k = 0; k < 12; k++) begin s1[k] = 0; s2[k] = 0; cl[k] = 0; fc[k] = 0; end
        end else begin
            int pgv, uvv, ovv, onv, hv, sel;
            bit clr_w;
            pgv = 0; uvv = 0; ovv = 0;
            for (int r = 0; r < 4; r++) begin
                pgv |= cl[r] << r; uvv |= cl[4 + r] << r; ovv |= cl[8 + r] << r;
            end
            onv = on_set(ms, mi);
            hv = (ms == 4) ? 0 : ((ovv & onv) | (uvv & good_set(ms, mi)));
            sel = 0;
            for (int r = 3; r >= 0; r--) if (hv[r]) sel = r;
            clr_w = reg_we && reg_addr == 3'd5;
            case (ms)
                0: begin mc = 0; if (en && !mfv) begin ms = 1; mi = 0; end end
                1, 2, 3: begin
                    if (hv != 0) begin
                        mfv = 1; mrl = sel; mcz = ((ovv & onv) >> sel) & 1 ? 2 : 1;
                        m_down();
                    end else if (ms == 2 && !pgv[mi] && mc == 63) begin
                        mfv = 1; mrl = mi; mcz = 3; m_down();
                    end else if (!en) m_down();
                    else if (ms == 1) begin
                        if (mc == mdly[mi]) begin ms = 2; mc = 0; end else mc++;
                    end else if (ms == 2) begin
                        if (pgv[mi]) begin
                            mc = 0;
                            if (mi == 3) ms = 3; else begin ms = 1; mi++; end
                        end else mc++;
                    end
                end
                4: begin
                    if (mc == mdly[mi]) begin
                        mc = 0;
                        if (mi == 0) ms = mfv ? 5 : 0; else mi--;
                    end else mc++;
                end
                default: if (clr_w) begin ms = 0; mfv = 0; mcz = 0; mrl = 0; end
            endcase
            for (int k = 0; k < 12; k++) begin
                int raw;
                raw = (k < 4) ? pg_in[k] : (k < 8) ? uv_in[k - 4] : ov_in[k - 8];
                if (s2[k] == cl[k]) fc[k] = 0;
                else if (fc[k] >= mflt) begin cl[k] = s2[k]; fc[k] = 0; end
                else fc[k] = (fc[k] + 1) & 15;
                s2[k] = s1[k]; s1[k] = raw;
            end
            if (reg_we) begin
                if (reg_addr < 3'd4) mdly[reg_addr] = reg_wdata;
                else if (reg_addr == 3'd4) mflt = reg_wdata & 15;
            end
        end
    end

    // Per-cycle comparison against the model, away from the edge.
    always @(posedge clk) begin
        #1;
        if (model_on) begin
            total++;
            if (rail_en !== 4'(on_set(ms, mi))) begin
                bad++; $display("FAIL R2 R3 rail_en act=%h exp=%h", rail_en, on_set(ms, mi));
            end
            total++;
            if (seq_done !== (ms == 3)) begin
                bad++; $display("FAIL R6 seq_done act=%b exp=%b", seq_done, ms == 3);
            end
            total++;
            if (irq !== (mfv != 0)) begin
                bad++; $display("FAIL R8 irq act=%b exp=%b", irq, mfv != 0);
            end
            if (reg_addr == 3'd5) begin
                total++;
                if (reg_rdata !== 16'(mstat())) begin
                    bad++; $display("FAIL R8 status act=%h exp=%h", reg_rdata, mstat());
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++; $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0; reg_addr = 3'd5;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
        @(negedge clk); reg_addr = a; #1;
        chk(req, reg_rdata, exp);
        @(negedge clk); reg_addr = 3'd5;
    endtask

    // cond: 0 done high, 1 irq high, 2 all rails off, 3 rail 1 on
    task automatic wait_for(input int cond, input int lim);
        for (int n = 0; n < lim; n++) begin
            @(negedge clk);
            if (cond == 0 && seq_done) return;
            if (cond == 1 && irq) return;
            if (cond == 2 && rail_en == 4'h0) return;
            if (cond == 3 && rail_en[1]) return;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        summary();
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1;
        @(negedge clk);
        chk("R1 rail_en", rail_en, 0);
        chk("R1 done", seq_done, 0);
        chk("R1 irq", irq, 0);
        chk("R1 status", reg_rdata, 0);

        // R3: program delays and filter length, read back.
        wr(3'd0, 16'd3); wr(3'd1, 16'd5); wr(3'd2, 16'd2); wr(3'd3, 16'd7);
        wr(3'd4, 16'd2);
        rd_chk("R3 dly0", 3'd0, 16'd3);
        rd_chk("R3 dly3", 3'd3, 16'd7);
        rd_chk("R10 filt", 3'd4, 16'd2);

        // R2 R6: power up.
        @(negedge clk); en = 1'b1;
        idle(3);
        chk("R6 done low during ramp", seq_done, 0);
        chk("R3 rail0 waits its delay", rail_en, 0);
        wait_for(0, 200);
        chk("R6 done", seq_done, 1);
        chk("R2 all on", rail_en, 4'hF);

        // R10: short undervoltage pulse is ignored.
        @(negedge clk); uv_in[2] = 1'b1;
        idle(2); uv_in[2] = 1'b0;
        idle(12);
        chk("R10 glitch no fault", irq, 0);
        chk("R10 still running", seq_done, 1);

        // R5: held undervoltage on rail 2.
        @(negedge clk); uv_in[2] = 1'b1;
        wait_for(1, 40);
        chk("R5 uv status", reg_rdata, 16'h8012);
        // R8: clear during shutdown is ignored.
        wr(3'd5, 16'd0);
        chk("R8 early clear ignored", irq, 1);
        chk("R8 early clear status", reg_rdata, 16'h8012);
        wait_for(2, 100);
        uv_in[2] = 1'b0;
        idle(20);
        chk("R7 rails held off", rail_en, 0);
        chk("R7 irq held", irq, 1);

        // R11 R4: stalled ramp on rail 1 with ignorable flags.
        pg_ok[1] = 1'b0;
        wr(3'd5, 16'd0);
        chk("R8 cleared", reg_rdata, 0);
        wait_for(3, 100);
        uv_in[1] = 1'b1; uv_in[3] = 1'b1; ov_in[3] = 1'b1;
        idle(30);
        chk("R11 no early fault", irq, 0);
        chk("R11 rails 0 and 1 on", rail_en, 4'h3);
        wait_for(1, 100);
        chk("R4 timeout status", reg_rdata, 16'h8031);
        uv_in = '0; ov_in = '0; pg_ok = 4'hF;
        wait_for(2, 100);
        idle(3);
        wr(3'd5, 16'd0);

        // R5: simultaneous OV and UV on rail 0, OV wins.
        wait_for(0, 200);
        chk("R6 done again", seq_done, 1);
        @(negedge clk); ov_in[0] = 1'b1; uv_in[0] = 1'b1;
        wait_for(1, 40);
        chk("R5 ov wins status", reg_rdata, 16'h8020);
        ov_in = '0; uv_in = '0;
        wait_for(2, 100);
        idle(3);
        wr(3'd5, 16'd0);
        wait_for(0, 200);

        // R8: clear outside the fault state has no effect.
        wr(3'd5, 16'd0);
        chk("R8 clear in run", reg_rdata, 0);
        chk("R8 run unaffected", seq_done, 1);

        // R9: orderly shutdown by enable.
        @(negedge clk); en = 1'b0;
        idle(2);
        chk("R9 done drops", seq_done, 0);
        wait_for(2, 100);
        idle(20);
        chk("R9 rails off", rail_en, 0);
        chk("R9 no fault", irq, 0);
        chk("R9 status", reg_rdata, 0);

        summary();
        $finish;
    end
endmodule